// File: doc/BRIEF.md
# Priority Interrupt Line Selector

This block chooses one interrupt line to hand to the processor for a single request class, either the normal or the fast class, fixed by a parameter. It takes four inputs for every line: a pending flag, a mask bit, a class-routing bit and a priority value. It also takes one global enable. From these it finds the most urgent eligible line and raises a request output. At the moment the request rises, the block latches the index of the winning line. Software reads that index from its own register file.

The request follows an agreement handshake. After reset, and after each re-arm strobe, the block is armed. While it is armed it evaluates the lines every clock. The first cycle that finds a candidate with the global enable on raises the request, latches the winner and disarms the block. From then on the request and the latched index stay frozen, whatever the lines do, until the next re-arm strobe drops the request. The block is armed again one cycle later.

None of the pins carries a data stream. Every pin is a plain level or strobe, with no valid/ready pairing and no back-pressure.

Top module: `prio_line_select`

## Requirements
- R1: A line is a candidate only when its pending bit is 1, its mask bit is 0 and its routing bit equals the class parameter (1 selects the fast class, 0 the normal class).
- R2: Among the candidates, the one with the numerically smallest priority value wins, and 0 is the most urgent value.
- R3: When several candidates share the smallest priority value, the one with the highest line index wins.
- R4: The winner index is bank × BANK_W + bit position. With the flat line numbering on the ports, this is the line's own position in the pending vector.
- R5: After reset the request is low and the latched index is 0.
- R6: The request rises at the first clock edge at which the block is armed, re-arm is low, the global enable is 1 and a candidate exists. The index latched at that edge is the winner at that edge.
- R7: While the global enable is 0, a low request stays low, whatever the lines do.
- R8: Once high, the request stays high and the latched index stays unchanged until a re-arm strobe, whatever the lines do.
- R9: A re-arm strobe sampled at an edge drives the request low after that edge. Evaluation resumes at the next edge, so a candidate that is still present raises the request one cycle later.
- R10: A re-arm strobe while the request is low leaves the request low and the latched index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | NUM_BANKS*BANK_W | Pending flag per line |
| mask_i | input | NUM_BANKS*BANK_W | Mask bit per line, 1 blocks the line |
| route_i | input | NUM_BANKS*BANK_W | Class-routing bit per line, 1 = fast class |
| prio_i | input | NUM_BANKS*BANK_W*PRIO_W | Priority per line, line k at bits [k*PRIO_W +: PRIO_W] |
| glob_en_i | input | 1 | Global enable for raising the request |
| rearm_i | input | 1 | One-cycle strobe that drops the request and re-arms |
| req_o | output | 1 | Request to the processor |
| win_o | output | idx_bits(NUM_BANKS*BANK_W) | Latched winner index |

## Verification
The hardest case to reach is a tie for the smallest priority value between several candidates, while masked, unpending or wrongly routed lines sit at an even smaller value. Only then do R1 and R3 show up together at the index. The bench uses a small configuration of eight lines with two-bit priorities. It steps through a long run of vectors from an LFSR, so that ties and decoys occur often, and adds directed all-equal and all-blocked patterns. Each vector is loaded while the block is armed and then released by a re-arm, so that every evaluation starts from a known handshake state.

// File: rtl/pil_pkg.sv
package pil_pkg;
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/pil_cand.sv
module pil_cand #(
  parameter int NL     = 96,
  parameter bit IS_FIQ = 1'b0
) (
  input  logic [NL-1:0] pend_i,
  input  logic [NL-1:0] mask_i,
  input  logic [NL-1:0] route_i,
  output logic [NL-1:0] cand_o
);
  // R1: per-line eligibility for this class
  for (genvar k = 0; k < NL; k++) begin : g_line
    assign cand_o[k] = pend_i[k] & ~mask_i[k] & (route_i[k] == IS_FIQ);
  end
endmodule

// File: rtl/pil_tree.sv
module pil_tree
  import pil_pkg::*;
#(
  parameter int NL     = 96,
  parameter int PRIO_W = 6,
  localparam int IDX_W  = idx_bits(NL),
  localparam int LEAVES = 1 << $clog2(NL),
  localparam int NODES  = 2 * LEAVES - 1
) (
  input  logic [NL-1:0]        cand_i,
  input  logic [NL*PRIO_W-1:0] prio_i,
  output logic                 any_o,
  output logic [IDX_W-1:0]     win_o
);
  logic              nv [NODES];
  logic [PRIO_W-1:0] np [NODES];
  logic [IDX_W-1:0]  ni [NODES];

  for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
    if (k < NL) begin : g_real
      assign nv[LEAVES-1+k] = cand_i[k];
      assign np[LEAVES-1+k] = prio_i[k*PRIO_W +: PRIO_W];
      assign ni[LEAVES-1+k] = IDX_W'(k);
    end else begin : g_pad
      assign nv[LEAVES-1+k] = 1'b0;
      assign np[LEAVES-1+k] = '1;
      assign ni[LEAVES-1+k] = '0;
    end
  end

  // R2/R3: the right (higher-index) child wins on equal priority
  for (genvar n = 0; n < LEAVES - 1; n++) begin : g_node
    logic take_hi;
    assign take_hi = nv[2*n+2] & (~nv[2*n+1] | (np[2*n+2] <= np[2*n+1]));
    assign nv[n]   = nv[2*n+1] | nv[2*n+2];
    assign np[n]   = take_hi ? np[2*n+2] : np[2*n+1];
    assign ni[n]   = take_hi ? ni[2*n+2] : ni[2*n+1];
  end

  assign any_o = nv[0];
  assign win_o = nv[0] ? ni[0] : '0;

  // The winner is a candidate and none beats it (R1, R2, R3).
  always_comb begin
    if (nv[0]) begin
      a_r1_winner_is_cand: assert (cand_i[ni[0]]);
      for (int k = 0; k < NL; k++) begin
        if (cand_i[k] && (k > int'(ni[0]))) begin
          a_r3_no_higher_tie: assert (prio_i[k*PRIO_W +: PRIO_W] > np[0]);
        end
        if (cand_i[k]) begin
          a_r2_min_prio: assert (prio_i[k*PRIO_W +: PRIO_W] >= np[0]);
        end
      end
    end else begin
      a_r1_none: assert (cand_i == '0);
    end
  end
endmodule

// File: rtl/pil_agree.sv
module pil_agree #(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             any_i,
  input  logic             en_i,
  input  logic             rearm_i,
  input  logic [IDX_W-1:0] win_i,
  output logic             req_o,
  output logic [IDX_W-1:0] win_o
);
  // The armed flag is the complement of the request, so one flop holds both.
  logic fire;
  assign fire = ~req_o & ~rearm_i & en_i & any_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_o <= 1'b0;
      win_o <= '0;
    end else if (rearm_i) begin
      req_o <= 1'b0;
    end else if (fire) begin
      req_o <= 1'b1;
      win_o <= win_i;
    end
  end

  a_r6_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_o && !rearm_i && en_i && any_i) |=> (req_o && win_o == $past(win_i)));
  a_r7_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_o && !en_i) |=> !req_o);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !rearm_i) |=> (req_o && $stable(win_o)));
  a_r9_drop: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_i |=> !req_o);
  a_r10_idle_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (rearm_i && !req_o) |=> $stable(win_o));
endmodule

// File: rtl/prio_line_select.sv
module prio_line_select
  import pil_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int BANK_W    = 32,
  parameter int PRIO_W    = 6,
  parameter bit IS_FIQ    = 1'b0,
  localparam int NL    = NUM_BANKS * BANK_W,
  localparam int IDX_W = idx_bits(NL)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NL-1:0]        pend_i,
  input  logic [NL-1:0]        mask_i,
  input  logic [NL-1:0]        route_i,
  input  logic [NL*PRIO_W-1:0] prio_i,
  input  logic                 glob_en_i,
  input  logic                 rearm_i,
  output logic                 req_o,
  output logic [IDX_W-1:0]     win_o
);
  logic [NL-1:0]    cand;
  logic             any;
  logic [IDX_W-1:0] win_comb;

  pil_cand #(.NL(NL), .IS_FIQ(IS_FIQ)) u_cand (
    .pend_i(pend_i), .mask_i(mask_i), .route_i(route_i), .cand_o(cand));

  // R4: flat line k is bank k/BANK_W, bit k%BANK_W, so the index is k itself
  pil_tree #(.NL(NL), .PRIO_W(PRIO_W)) u_tree (
    .cand_i(cand), .prio_i(prio_i), .any_o(any), .win_o(win_comb));

  pil_agree #(.IDX_W(IDX_W)) u_agree (
    .clk(clk), .rst_n(rst_n), .any_i(any), .en_i(glob_en_i),
    .rearm_i(rearm_i), .win_i(win_comb), .req_o(req_o), .win_o(win_o));
endmodule

// File: tb/tb_prio_line_select.sv
module tb_prio_line_select;
  localparam int NB = 2, BW = 4, PW = 2, NL = NB * BW, IW = 3;
  localparam bit CLS = 1'b1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NL-1:0] pend = '0, mask = '1, route = '0;
  logic [NL*PW-1:0] prio = '0;
  logic en = 1'b0, rearm = 1'b0;
  logic req;
  logic [IW-1:0] win;
  int checks = 0, fails = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #2 clk = ~clk;

  prio_line_select #(.NUM_BANKS(NB), .BANK_W(BW), .PRIO_W(PW), .IS_FIQ(CLS)) dut (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .mask_i(mask), .route_i(route),
    .prio_i(prio), .glob_en_i(en), .rearm_i(rearm), .req_o(req), .win_o(win));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Model: R1 eligibility, R2 lowest value, R3 highest index on ties
  function automatic int model(output bit found);
    int best = 0, bp = 1 << PW;
    found = 0;
    for (int k = 0; k < NL; k++) begin
      if (pend[k] && !mask[k] && route[k] == CLS) begin
        int p = int'(prio[k*PW +: PW]);
        if (p <= bp) begin bp = p; best = k; found = 1; end
      end
    end
    return best;
  endfunction

  function automatic logic [31:0] step(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  // Armed and rearm low: one edge evaluates the present inputs (R6)
  task automatic eval_and_release(input string tag);
    bit f; int w;
    w = model(f);
    cyc();
    chk({tag, " R6 req"}, int'(req), int'(f & en));
    if (f && en) chk({tag, " R2/R3/R4 win"}, int'(win), w);
    rearm = 1'b1;
    cyc();
    rearm = 1'b0;
    chk({tag, " R9 drop"}, int'(req), 0);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R5 reset req", int'(req), 0);
    chk("R5 reset win", int'(win), 0);
    rst_n = 1'b1;
    cyc();
    chk("R5 masked idle", int'(req), 0);

    // R3: all equal priority -> highest line
    en = 1'b1; pend = '1; mask = '0; route = '1; prio = '0;
    eval_and_release("R3 all-equal");
    // R1: wrong routing blocks everything
    route = '0;
    eval_and_release("R1 wrong-class");
    // R1: masked lines with urgent prio as decoys; R2 picks line 2
    route = '1; mask = 8'b1000_0001;
    prio = {2'd0, 2'd3, 2'd3, 2'd2, 2'd3, 2'd1, 2'd3, 2'd0};
    eval_and_release("R1 R2 decoy");

    // R7: enable off keeps request low
    en = 1'b0; mask = '0;
    cyc(); cyc();
    chk("R7 enable off", int'(req), 0);
    // R6: turning enable on raises it; R4 line in bank 1 bit 3 = index 7
    en = 1'b1;
    cyc();
    chk("R6 rise", int'(req), 1);
    chk("R4 index", int'(win), 7);
    // R8: inputs change, request and index hold
    pend = 8'b0000_0010; prio = '1;
    cyc(); cyc();
    chk("R8 hold req", int'(req), 1);
    chk("R8 hold win", int'(win), 7);
    // R9: rearm drops, candidate still present -> back up one cycle later
    rearm = 1'b1;
    cyc();
    rearm = 1'b0;
    chk("R9 drop", int'(req), 0);
    cyc();
    chk("R9 re-raise", int'(req), 1);
    chk("R9 new win", int'(win), 1);
    // R10: rearm while low changes nothing
    rearm = 1'b1; cyc();
    pend = '0;
    cyc(); rearm = 1'b0;
    chk("R10 req", int'(req), 0);
    chk("R10 win", int'(win), 1);

    // Sweep
    for (int v = 0; v < 3000; v++) begin
      lfsr = step(lfsr); pend = lfsr[7:0]; mask = lfsr[15:8] & lfsr[23:16];
      lfsr = step(lfsr); route = lfsr[7:0] | lfsr[31:24]; prio = lfsr[23:8];
      en = (v % 7) != 0;
      eval_and_release("sweep");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule